// File: doc/BRIEF.md
# AHB Subordinate Transfer Qualifier

This block sits at the front of an AHB subordinate. Every clock it reads the transfer-type code, the select line and the bus-advance line, and decides whether a real access has been handed to this subordinate. A committed address phase is captured, and in the following cycle a single-cycle access strobe is given, with the captured address and direction, to a simple register file or memory array behind the block.

The block also follows burst structure. A fresh-address transfer opens a context when the burst-type input marks an incrementing burst. A pause beat keeps that context alive and an idle beat ends it. From each real beat it works out the address that the next sequential beat should carry, which is the current address plus the beat size in bytes. A sequential beat that arrives at any other address, or with no burst open, raises a one-cycle debug flag alongside its strobe. The subordinate is always ready and always answers OKAY.

Top module: `ahbs_xfer_qual`

## Requirements
- R1: The access strobe `acc_valid` is high in the cycle after a clock edge at which `trans_in` was 2'b10 (fresh address) or 2'b11 (sequential), `sel_in` was 1 and `ready_in` was 1. It is low after every other edge.
- R2: When `acc_valid` is high, `acc_addr` and `acc_write` equal the `addr_in` and `write_in` values present at the committing edge.
- R3: Transfer codes 2'b00 (idle) and 2'b01 (pause) never produce an access. `rdy_out` is always 1 and `resp_out` is always 0 (OKAY).
- R4: While `ready_in` is 0, no access is produced, and `burst_active` and `next_addr_exp` keep their values.
- R5: A selected, advancing 2'b10 beat sets `burst_active` to the value of `incr_in` (1 means an incrementing burst, 0 means a single transfer).
- R6: After a selected, advancing 2'b10 or 2'b11 beat, `next_addr_exp` equals that beat's `addr_in` plus 2 to the power `size_in`, modulo 2^ADDR_W.
- R7: A selected, advancing 2'b01 beat leaves `burst_active` and `next_addr_exp` unchanged.
- R8: A selected, advancing 2'b00 beat clears `burst_active`, and so does any advancing cycle with `sel_in` low.
- R9: `seq_mismatch` is high for exactly the cycle after a selected, advancing 2'b11 beat whose `addr_in` differs from `next_addr_exp` or that arrives while `burst_active` is 0. It is low otherwise.
- R10: Synchronous active-high reset clears `acc_valid`, `burst_active`, `seq_mismatch` and `next_addr_exp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_in | input | 1 | This subordinate is selected |
| trans_in | input | 2 | Transfer-type code |
| addr_in | input | ADDR_W | Address-phase address |
| write_in | input | 1 | Address-phase direction, 1 = write |
| size_in | input | 3 | Beat size as log2 of bytes |
| incr_in | input | 1 | Burst-type indication, 1 = incrementing burst |
| ready_in | input | 1 | Bus advance (previous transfer completing) |
| acc_valid | output | 1 | Data-phase access strobe |
| acc_addr | output | ADDR_W | Captured access address |
| acc_write | output | 1 | Captured access direction |
| next_addr_exp | output | ADDR_W | Predicted address of the next sequential beat |
| burst_active | output | 1 | Burst context open |
| seq_mismatch | output | 1 | Sequential beat off-pattern or outside a burst |
| rdy_out | output | 1 | Subordinate ready, held at 1 |
| resp_out | output | 1 | Response, held at OKAY (0) |

## Verification
The case that is hardest to reach from the ports is a pause beat that follows a burst whose prediction is still valid, with a bus stall mixed in and then a sequential beat that must match the prediction held across both. Uniform random codes rarely give this ordering. So the random stimulus reads the bench model's expected address and, for most sequential beats, drives it back, which lets long legal bursts form with pauses and stalls inside them. Directed sequences add the exact pause-then-resume, idle-then-sequential and single-transfer-then-sequential patterns.

// File: rtl/xq_pkg.sv
package xq_pkg;

    // Transfer-type codes; the bit values are fixed by the bus protocol.
    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    // Per-cycle classification produced by the front decoder.
    typedef struct packed {
        logic   commit;     // real beat, selected, bus advancing
        logic   sel_adv;    // selected and bus advancing (any code)
        logic   adv_other;  // bus advancing, this subordinate not selected
        trans_e kind;       // decoded transfer type
    } qual_t;

    localparam int SIZE_W = 3;

    // A code carries a real access when its upper bit is set.
    function automatic logic is_real(trans_e k);
        return (k == TR_NONSEQ) || (k == TR_SEQ);
    endfunction

    function automatic trans_e to_trans(logic [1:0] raw);
        return trans_e'(raw);
    endfunction

endpackage

// File: rtl/xq_classify.sv
module xq_classify
    import xq_pkg::*;
(
    input  logic        sel_in,
    input  logic [1:0]  trans_in,
    input  logic        ready_in,
    output qual_t       q
);

    trans_e kind;

    always_comb begin
        kind        = to_trans(trans_in);
        q.kind      = kind;
        q.sel_adv   = sel_in & ready_in;
        q.adv_other = ready_in & ~sel_in;
        // Only a real code, selected, on an advancing cycle is committed.
        q.commit    = sel_in & ready_in & is_real(kind);
    end

endmodule

// File: rtl/xq_data_phase.sv
module xq_data_phase
    import xq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  qual_t             q,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              write_in,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_write
);

    // Address-phase values are captured only on a committed edge; the
    // strobe is a one-cycle pulse in the following data phase.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid <= 1'b0;
            acc_addr  <= '0;
            acc_write <= 1'b0;
        end else begin
            acc_valid <= q.commit;
            if (q.commit) begin
                acc_addr  <= addr_in;
                acc_write <= write_in;
            end
        end
    end

endmodule

// File: rtl/xq_burst_track.sv
module xq_burst_track
    import xq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  qual_t             q,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [SIZE_W-1:0] size_in,
    input  logic              incr_in,
    output logic              burst_active,
    output logic [ADDR_W-1:0] next_addr_exp,
    output logic              seq_mismatch
);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] next_calc;
    logic              off_pattern;

    always_comb begin
        step        = ADDR_W'(1) << size_in;
        next_calc   = addr_in + step;
        off_pattern = !burst_active || (addr_in != next_addr_exp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_active  <= 1'b0;
            next_addr_exp <= '0;
            seq_mismatch  <= 1'b0;
        end else begin
            seq_mismatch <= 1'b0;
            if (q.sel_adv) begin
                unique case (q.kind)
                    TR_NONSEQ: begin
                        burst_active  <= incr_in;
                        next_addr_exp <= next_calc;
                    end
                    TR_SEQ: begin
                        seq_mismatch  <= off_pattern;
                        next_addr_exp <= next_calc;
                    end
                    TR_BUSY: begin
                        // pause: context and prediction held
                    end
                    TR_IDLE: begin
                        burst_active <= 1'b0;
                    end
                    default: begin
                        burst_active <= 1'b0;
                    end
                endcase
            end else if (q.adv_other) begin
                // bus moved on to another subordinate: context is gone
                burst_active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ahbs_xfer_qual.sv
module ahbs_xfer_qual
    import xq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_in,
    input  logic [1:0]        trans_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              write_in,
    input  logic [2:0]        size_in,
    input  logic              incr_in,
    input  logic              ready_in,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_write,
    output logic [ADDR_W-1:0] next_addr_exp,
    output logic              burst_active,
    output logic              seq_mismatch,
    output logic              rdy_out,
    output logic              resp_out
);

    qual_t q;

    xq_classify u_classify (
        .sel_in   (sel_in),
        .trans_in (trans_in),
        .ready_in (ready_in),
        .q        (q)
    );

    xq_data_phase #(.ADDR_W(ADDR_W)) u_dphase (
        .clk       (clk),
        .rst       (rst),
        .q         (q),
        .addr_in   (addr_in),
        .write_in  (write_in),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_write (acc_write)
    );

    xq_burst_track #(.ADDR_W(ADDR_W)) u_burst (
        .clk           (clk),
        .rst           (rst),
        .q             (q),
        .addr_in       (addr_in),
        .size_in       (size_in),
        .incr_in       (incr_in),
        .burst_active  (burst_active),
        .next_addr_exp (next_addr_exp),
        .seq_mismatch  (seq_mismatch)
    );

    // Zero-wait, never-error response.
    assign rdy_out  = 1'b1;
    assign resp_out = 1'b0;

endmodule

// File: rtl/xq_checker.sv
module xq_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_in,
    input logic [1:0]        trans_in,
    input logic [ADDR_W-1:0] addr_in,
    input logic              write_in,
    input logic              ready_in,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_write,
    input logic [ADDR_W-1:0] next_addr_exp,
    input logic              burst_active,
    input logic              seq_mismatch,
    input logic              rdy_out,
    input logic              resp_out
);

    // R1
    commit_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_in && ready_in && trans_in[1]) |=> acc_valid);

    // R2
    capture_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_in && ready_in && trans_in[1]) |=>
            (acc_addr == $past(addr_in) && acc_write == $past(write_in)));

    // R3
    no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_in && ready_in && !trans_in[1]) |=> !acc_valid);

    // R3
    okay_resp_chk: assert property (@(posedge clk) disable iff (rst)
        rdy_out && !resp_out);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ready_in |=> (!acc_valid && $stable(burst_active) && $stable(next_addr_exp)));

    // R7
    pause_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_in && ready_in && trans_in == 2'b01) |=>
            ($stable(burst_active) && $stable(next_addr_exp)));

    // R8
    idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ready_in && (!sel_in || trans_in == 2'b00)) |=> !burst_active);

    // R9
    flag_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        seq_mismatch |-> acc_valid);

endmodule

bind ahbs_xfer_qual xq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sel_in        (sel_in),
    .trans_in      (trans_in),
    .addr_in       (addr_in),
    .write_in      (write_in),
    .ready_in      (ready_in),
    .acc_valid     (acc_valid),
    .acc_addr      (acc_addr),
    .acc_write     (acc_write),
    .next_addr_exp (next_addr_exp),
    .burst_active  (burst_active),
    .seq_mismatch  (seq_mismatch),
    .rdy_out       (rdy_out),
    .resp_out      (resp_out)
);

// File: tb/ahbs_xfer_qual_tb.sv
module ahbs_xfer_qual_tb;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_in = 1'b0;
    logic [1:0]    trans_in = 2'b00;
    logic [AW-1:0] addr_in = '0;
    logic          write_in = 1'b0;
    logic [2:0]    size_in = 3'd0;
    logic          incr_in = 1'b0;
    logic          ready_in = 1'b1;
    logic          acc_valid, acc_write, burst_active, seq_mismatch, rdy_out, resp_out;
    logic [AW-1:0] acc_addr, next_addr_exp;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model state
    logic          m_valid = 0, m_write = 0, m_burst = 0, m_mis = 0;
    logic [AW-1:0] m_addr = '0, m_exp = '0;

    always #2 clk = ~clk;

    ahbs_xfer_qual #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .sel_in(sel_in), .trans_in(trans_in),
        .addr_in(addr_in), .write_in(write_in), .size_in(size_in),
        .incr_in(incr_in), .ready_in(ready_in), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write),
        .next_addr_exp(next_addr_exp), .burst_active(burst_active),
        .seq_mismatch(seq_mismatch), .rdy_out(rdy_out), .resp_out(resp_out)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference behaviour written from the requirements.
    task automatic model_step();
        logic          adv_sel;
        logic [AW-1:0] nxt;
        adv_sel = sel_in && ready_in;
        nxt     = addr_in + (AW'(1) << size_in);
        m_mis   = 1'b0;
        m_valid = adv_sel && trans_in[1];                       // R1
        if (m_valid) begin m_addr = addr_in; m_write = write_in; end   // R2
        if (adv_sel) begin
            case (trans_in)
                2'b10: begin m_burst = incr_in; m_exp = nxt; end   // R5 R6
                2'b11: begin
                    m_mis = !m_burst || (addr_in != m_exp);        // R9
                    m_exp = nxt;
                end
                2'b01: ;                                           // R7
                default: m_burst = 1'b0;                           // R8
            endcase
        end else if (ready_in) begin
            m_burst = 1'b0;                                        // R8
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R1"}, "acc_valid", 64'(acc_valid), 64'(m_valid));
        if (m_valid) begin
            chk({tag, " R2"}, "acc_addr", 64'(acc_addr), 64'(m_addr));
            chk({tag, " R2"}, "acc_write", 64'(acc_write), 64'(m_write));
        end
        chk({tag, " R5/R7/R8"}, "burst_active", 64'(burst_active), 64'(m_burst));
        chk({tag, " R6"}, "next_addr_exp", 64'(next_addr_exp), 64'(m_exp));
        chk({tag, " R9"}, "seq_mismatch", 64'(seq_mismatch), 64'(m_mis));
        chk({tag, " R3"}, "rdy_out/resp_out", {62'd0, rdy_out, resp_out}, 64'h2);
    endtask

    task automatic beat(input string tag, input logic s, input logic [1:0] t,
                        input logic [AW-1:0] a, input logic w, input logic [2:0] z,
                        input logic inc, input logic r);
        sel_in = s; trans_in = t; addr_in = a; write_in = w;
        size_in = z; incr_in = inc; ready_in = r;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // drive a pending NONSEQ during reset; reset must win
        sel_in = 1; trans_in = 2'b10; addr_in = 32'h55; incr_in = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check_all("R10 reset");
        rst = 1'b0;

        // directed incrementing burst with a pause and a stall
        beat("R3 idle",        1, 2'b00, 32'h0000_0000, 0, 3'd2, 0, 1);
        beat("R5 open",        1, 2'b10, 32'h0000_0100, 1, 3'd2, 1, 1);
        beat("R6 seq1",        1, 2'b11, 32'h0000_0104, 1, 3'd2, 1, 1);
        beat("R7 pause",       1, 2'b01, 32'h0000_0108, 1, 3'd2, 1, 1);
        beat("R4 stall",       1, 2'b11, 32'h0000_0108, 1, 3'd2, 1, 0);
        beat("R7 resume",      1, 2'b11, 32'h0000_0108, 1, 3'd2, 1, 1);
        beat("R9 offpattern",  1, 2'b11, 32'h0000_0200, 0, 3'd2, 1, 1);
        beat("R8 idle drop",   1, 2'b00, 32'h0000_0000, 0, 3'd2, 0, 1);
        beat("R9 seq no ctx",  1, 2'b11, 32'h0000_0010, 0, 3'd0, 0, 1);
        beat("R5 single",      1, 2'b10, 32'h0000_0040, 1, 3'd1, 0, 1);
        beat("R9 after single",1, 2'b11, 32'h0000_0042, 1, 3'd1, 0, 1);
        beat("R4 no ready",    1, 2'b10, 32'h0000_0080, 1, 3'd0, 1, 0);
        beat("R1 unselected",  0, 2'b10, 32'h0000_0090, 1, 3'd0, 1, 1);
        beat("R6 wrap",        1, 2'b10, 32'hFFFF_FFFC, 0, 3'd2, 1, 1);
        beat("R8 other sub",   0, 2'b11, 32'h0000_0000, 0, 3'd2, 1, 1);

        // constrained random traffic steered along legal bursts
        for (int i = 0; i < 3000; i++) begin
            logic          s, r, w, inc;
            logic [1:0]    t;
            logic [2:0]    z;
            logic [AW-1:0] a;
            s   = ($urandom_range(9) < 8);
            r   = ($urandom_range(9) < 8);
            w   = 1'($urandom_range(1));
            inc = ($urandom_range(3) != 0);
            z   = 3'($urandom_range(2));
            t   = 2'($urandom_range(3));
            if (m_burst && $urandom_range(3) != 0)
                t = ($urandom_range(4) == 0) ? 2'b01 : 2'b11;
            a   = $urandom() & ~((AW'(1) << z) - 1);
            if (t == 2'b11 && $urandom_range(7) != 0) a = m_exp;
            beat("R1..rand", s, t, a, w, z, inc, r);
        end

        // final reset mid-burst
        beat("R5 reopen", 1, 2'b10, 32'h0000_1000, 1, 3'd2, 1, 1);
        rst = 1'b1;
        @(posedge clk);
        m_valid = 0; m_burst = 0; m_mis = 0; m_exp = '0;
        @(negedge clk);
        check_all("R10 mid reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule